// File: doc/BRIEF.md
# Socket Status-Change Interrupt Mask

This block holds the software-programmable enables that decide which socket events may raise the status-change interrupt of a card socket controller. Three kinds of latched event flag arrive from an event register outside the block: a power-cycle flag, a pair of card-detect flags (insertion or removal), and a card-status flag. Each flag has its own enable field in a 32-bit register. The block drives a single registered interrupt level. This level is high while at least one enabled flag is set.

Software reaches the register through a plain word port. The port has a write strobe, four byte enables, an address and write data, and it returns read data combinationally. The register sits at offset 04h. Only its low four bits are implemented.

Two resets act on the block. The global reset always clears everything. The platform reset clears the interrupt in every case. It clears the enable bits only while power-management event signalling is disabled, so the enables persist across a platform reset when that feature is on. The mask decides only whether a flag reaches the interrupt. It never touches the flags themselves, which are latched outside.

Top module: `sc_irq_mask`

## Requirements
- R1: After global reset, a read at offset 04h returns 0000_0000h and the interrupt output is 0.
- R2: Bits 31 to 4 of the register always read as 0, whatever was written to them.
- R3: A write with the strobe high, address 04h and byte enable bit 0 set loads write-data bits 3:0 into the register at the next clock edge. A write to any other address, or with byte enable bit 0 clear, leaves the register unchanged. A read at any address other than 04h returns 0.
- R4: Bit 3 enables the power-cycle flag. With bit 3 at 1 and the flag set, the interrupt is 1 one cycle later. With bit 3 at 0, the flag alone never raises the interrupt.
- R5: Bits 2:1 enable the card-detect flags only when they hold 11. With any other value, either card-detect flag alone never raises the interrupt. The values 01 and 10 are stored and read back exactly as written.
- R6: Bit 0 enables the card-status flag. With bit 0 at 1 and the flag set, the interrupt is 1 one cycle later. With bit 0 at 0, the flag alone never raises the interrupt.
- R7: The interrupt is registered. After each clock edge it equals the OR, over all three kinds, of each flag ANDed with its enable, both sampled at that edge. It stays high as long as an enabled flag stays set.
- R8: A platform reset with power-management enable at 1 leaves bits 3:0 unchanged and clears the interrupt. With power-management enable at 0, it clears bits 3:0 and the interrupt at the next clock edge.
- R9: Global reset clears bits 3:0 and the interrupt at once, whatever the value of power-management enable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| grst_n | input | 1 | Global reset, asynchronous, active low |
| prst_n | input | 1 | Platform reset, sampled on the clock, active low |
| pm_en | input | 1 | Power-management event enable; makes the enables survive platform reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W (8) | Byte offset within the socket register space |
| be | input | DATA_W/8 (4) | Byte enables for the write |
| wdata | input | DATA_W (32) | Write data |
| rdata | output | DATA_W (32) | Combinational read data |
| evt_pwr | input | 1 | Latched power-cycle flag |
| evt_cd | input | 2 | Latched card-detect flags |
| evt_sts | input | 1 | Latched card-status flag |
| irq | output | 1 | Registered status-change interrupt level |

## Verification
The bench builds the block with its default parameters: an 8-bit address with the register at 04h and a 32-bit data path. This puts every implemented and reserved bit, all four byte lanes and the neighbouring addresses within reach of random writes. Random flag patterns combined with random enable values cover each path to the interrupt, including the two reserved card-detect patterns. Platform reset is applied with power-management enable both set and clear. Global reset is applied in the middle of a run.

// File: rtl/sc_mask_pkg.sv
package sc_mask_pkg;

    localparam int MASK_W = 4;

    // Field order matches bit positions 3..0 of the register.
    typedef struct packed {
        logic       pwr;   // bit 3
        logic [1:0] cd;    // bits 2:1, only 2'b11 enables
        logic       sts;   // bit 0
    } mask_t;

    localparam logic [1:0] CD_ON = 2'b11;

endpackage

// File: rtl/sc_mask_reg.sv
module sc_mask_reg
    import sc_mask_pkg::*;
(
    input  logic  clk,
    input  logic  grst_n,
    input  logic  prst_n,
    input  logic  pm_en,
    input  logic  wr_hit,
    input  mask_t wbits,
    output mask_t mask
);

    logic plat_clr;
    assign plat_clr = !prst_n && !pm_en;

    always_ff @(posedge clk or negedge grst_n) begin
        if (!grst_n)
            mask <= '0;
        else if (plat_clr)
            mask <= '0;
        else if (wr_hit)
            mask <= wbits;
    end

    // R8: with power management on, platform reset keeps the enables.
    a_r8_sticky: assert property (@(posedge clk) disable iff (!grst_n)
        (!prst_n && pm_en && !wr_hit) |=> $stable(mask));

    // R8: without power management, platform reset clears them.
    a_r8_clear: assert property (@(posedge clk) disable iff (!grst_n)
        (!prst_n && !pm_en) |=> (mask == '0));

    // R3: an accepted write shows up on the next edge.
    a_r3_write: assert property (@(posedge clk) disable iff (!grst_n)
        (wr_hit && !(!prst_n && !pm_en)) |=> (mask == $past(wbits)));

    // R9: global reset holds the enables at zero.
    always @(posedge clk) begin
        if (!grst_n)
            a_r9_grst_clear: assert (mask == '0);
    end

endmodule

// File: rtl/sc_mask_gate.sv
module sc_mask_gate
    import sc_mask_pkg::*;
(
    input  logic       clk,
    input  logic       grst_n,
    input  logic       prst_n,
    input  mask_t      mask,
    input  logic       evt_pwr,
    input  logic [1:0] evt_cd,
    input  logic       evt_sts,
    output logic       irq
);

    logic hit_pwr, hit_cd, hit_sts, irq_next;

    always_comb begin
        hit_pwr  = evt_pwr && mask.pwr;
        hit_cd   = (|evt_cd) && (mask.cd == CD_ON);
        hit_sts  = evt_sts && mask.sts;
        irq_next = hit_pwr || hit_cd || hit_sts;
    end

    always_ff @(posedge clk or negedge grst_n) begin
        if (!grst_n)
            irq <= 1'b0;
        else if (!prst_n)
            irq <= 1'b0;
        else
            irq <= irq_next;
    end

    a_r4_pwr_raises: assert property (@(posedge clk) disable iff (!grst_n)
        (prst_n && mask.pwr && evt_pwr) |=> irq);

    a_r6_sts_raises: assert property (@(posedge clk) disable iff (!grst_n)
        (prst_n && mask.sts && evt_sts) |=> irq);

    // R5: a non-11 card-detect field alone never raises the interrupt.
    a_r5_cd_blocked: assert property (@(posedge clk) disable iff (!grst_n)
        ((mask.cd != CD_ON) && !(evt_pwr && mask.pwr) && !(evt_sts && mask.sts)) |=> !irq);

    a_r7_irq_cause: assert property (@(posedge clk) disable iff (!grst_n)
        irq |-> $past((evt_pwr && mask.pwr) || ((|evt_cd) && mask.cd[1] && mask.cd[0]) ||
                      (evt_sts && mask.sts)));

endmodule

// File: rtl/sc_irq_mask.sv
module sc_irq_mask
    import sc_mask_pkg::*;
#(
    parameter int              DATA_W   = 32,
    parameter int              ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] MASK_OFS = 8'h04
) (
    input  logic                  clk,
    input  logic                  grst_n,
    input  logic                  prst_n,
    input  logic                  pm_en,
    input  logic                  wr_en,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [DATA_W/8-1:0]   be,
    input  logic [DATA_W-1:0]     wdata,
    output logic [DATA_W-1:0]     rdata,
    input  logic                  evt_pwr,
    input  logic [1:0]            evt_cd,
    input  logic                  evt_sts,
    output logic                  irq
);

    localparam int RSVD_W = DATA_W - MASK_W;

    logic  sel, wr_hit;
    mask_t wbits, mask;
    logic  unused_rsvd;

    assign sel         = (addr == MASK_OFS);
    assign wr_hit      = wr_en && sel && be[0];
    assign wbits       = mask_t'(wdata[MASK_W-1:0]);
    assign unused_rsvd = ^{wdata[DATA_W-1:MASK_W], be[DATA_W/8-1:1]};

    sc_mask_reg u_reg (
        .clk    (clk),
        .grst_n (grst_n),
        .prst_n (prst_n),
        .pm_en  (pm_en),
        .wr_hit (wr_hit),
        .wbits  (wbits),
        .mask   (mask)
    );

    sc_mask_gate u_gate (
        .clk     (clk),
        .grst_n  (grst_n),
        .prst_n  (prst_n),
        .mask    (mask),
        .evt_pwr (evt_pwr),
        .evt_cd  (evt_cd),
        .evt_sts (evt_sts),
        .irq     (irq)
    );

    always_comb begin
        rdata = '0;
        if (sel)
            rdata = {{RSVD_W{1'b0}}, mask};
    end

    a_r2_rsvd_zero: assert property (@(posedge clk) disable iff (!grst_n)
        rdata[DATA_W-1:MASK_W] == '0);

    a_r3_other_addr_zero: assert property (@(posedge clk) disable iff (!grst_n)
        !sel |-> (rdata == '0));

endmodule

// File: tb/sc_irq_mask_bench.sv
`timescale 1ns/1ps
module sc_irq_mask_bench;

    logic        clk = 1'b0;
    logic        grst_n = 1'b0, prst_n = 1'b1, pm_en = 1'b0, wr_en = 1'b0;
    logic [7:0]  addr = 8'h04;
    logic [3:0]  be = 4'h0;
    logic [31:0] wdata = '0, rdata;
    logic        evt_pwr = 1'b0, evt_sts = 1'b0, irq;
    logic [1:0]  evt_cd = 2'b00;

    int n_chk = 0, n_fail = 0;
    logic [3:0] m_exp = 4'h0;
    logic       irq_exp = 1'b0;
    bit         done = 1'b0;

    always #5 clk = ~clk;

    sc_irq_mask u_sc_irq_mask (
        .clk(clk), .grst_n(grst_n), .prst_n(prst_n), .pm_en(pm_en),
        .wr_en(wr_en), .addr(addr), .be(be), .wdata(wdata), .rdata(rdata),
        .evt_pwr(evt_pwr), .evt_cd(evt_cd), .evt_sts(evt_sts), .irq(irq)
    );

    function automatic logic f_irq(logic [3:0] m, logic p, logic [1:0] c, logic s);
        return (p && m[3]) || ((|c) && m[2:1] == 2'b11) || (s && m[0]);
    endfunction

    function automatic logic [31:0] f_rd(logic [3:0] m, logic [7:0] a);
        return (a == 8'h04) ? {28'h0, m} : 32'h0;
    endfunction

    task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One clock: model the edge, then compare at the falling edge.
    task automatic cyc();
        @(posedge clk);
        if (!grst_n) begin
            m_exp = 4'h0; irq_exp = 1'b0;
        end else begin
            irq_exp = prst_n ? f_irq(m_exp, evt_pwr, evt_cd, evt_sts) : 1'b0;
            if (!prst_n && !pm_en) m_exp = 4'h0;
            else if (wr_en && addr == 8'h04 && be[0]) m_exp = wdata[3:0];
        end
        @(negedge clk);
        chk(irq == irq_exp, "R7", {31'h0, irq}, {31'h0, irq_exp});
        chk(rdata == f_rd(m_exp, addr), "R3", rdata, f_rd(m_exp, addr));
    endtask

    task automatic wr(logic [31:0] d);
        wr_en = 1'b1; addr = 8'h04; be = 4'hF; wdata = d;
        cyc();
        wr_en = 1'b0;
    endtask

    task automatic evt(logic p, logic [1:0] c, logic s);
        evt_pwr = p; evt_cd = c; evt_sts = s;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5C1A));
        repeat (2) @(negedge clk);
        chk(rdata == 32'h0, "R1", rdata, 32'h0);
        chk(irq == 1'b0, "R1", {31'h0, irq}, 32'h0);
        grst_n = 1'b1;
        cyc();

        // R2: reserved bits read zero.
        wr(32'hFFFF_FFFF);
        chk(rdata == 32'h0000_000F, "R2", rdata, 32'h0000_000F);

        // R3: byte-lane 0 off and wrong address are ignored.
        wr_en = 1'b1; be = 4'hE; wdata = 32'h0; cyc();
        wr_en = 1'b0; be = 4'h0;
        chk(rdata == 32'hF, "R3", rdata, 32'hF);
        wr_en = 1'b1; addr = 8'h08; be = 4'hF; cyc();
        wr_en = 1'b0; addr = 8'h04; #1;
        chk(rdata == 32'hF, "R3", rdata, 32'hF);

        // R4: power-cycle enable.
        wr(32'h8); evt(1, 2'b00, 0); cyc();
        chk(irq == 1'b1, "R4", {31'h0, irq}, 32'h1);
        wr(32'h0); cyc();
        chk(irq == 1'b0, "R4", {31'h0, irq}, 32'h0);

        // R5: only 11 enables card detect; 01/10 stored.
        evt(0, 2'b11, 0);
        wr(32'h2); chk(rdata == 32'h2, "R5", rdata, 32'h2);
        cyc(); chk(irq == 1'b0, "R5", {31'h0, irq}, 32'h0);
        wr(32'h4); chk(rdata == 32'h4, "R5", rdata, 32'h4);
        cyc(); chk(irq == 1'b0, "R5", {31'h0, irq}, 32'h0);
        wr(32'h6); evt(0, 2'b01, 0); cyc();
        chk(irq == 1'b1, "R5", {31'h0, irq}, 32'h1);

        // R6: card-status enable.
        wr(32'h1); evt(0, 2'b00, 1); cyc();
        chk(irq == 1'b1, "R6", {31'h0, irq}, 32'h1);
        wr(32'hE); cyc();
        chk(irq == 1'b0, "R6", {31'h0, irq}, 32'h0);

        // R8: platform reset with and without power management.
        wr(32'hB); evt(1, 2'b00, 0); cyc();
        pm_en = 1'b1; prst_n = 1'b0; cyc();
        chk(rdata == 32'hB, "R8", rdata, 32'hB);
        chk(irq == 1'b0, "R8", {31'h0, irq}, 32'h0);
        pm_en = 1'b0; cyc();
        chk(rdata == 32'h0, "R8", rdata, 32'h0);
        prst_n = 1'b1; evt(0, 2'b00, 0); cyc();

        // R9: global reset clears even with power management on.
        wr(32'hF); pm_en = 1'b1; evt(1, 2'b10, 1); cyc();
        grst_n = 1'b0; #1;
        chk(rdata == 32'h0, "R9", rdata, 32'h0);
        chk(irq == 1'b0, "R9", {31'h0, irq}, 32'h0);
        m_exp = 4'h0; irq_exp = 1'b0;
        cyc();
        grst_n = 1'b1; cyc();

        // Random phase.
        for (int i = 0; i < 400; i++) begin
            wr_en   = ($urandom % 3) == 0;
            addr    = ($urandom % 2) ? 8'h04 : 8'($urandom % 16);
            be      = 4'($urandom);
            wdata   = $urandom;
            evt_pwr = $urandom % 2;
            evt_cd  = 2'($urandom);
            evt_sts = $urandom % 2;
            pm_en   = $urandom % 2;
            prst_n  = ($urandom % 10) != 0;
            cyc();
            chk(rdata[31:4] == 28'h0, "R2", rdata, {4'h0, rdata[27:0]} & 32'hF);
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule